// File: doc/BRIEF.md
# Framed 48-Slot Serial Link Endpoint

This block is the remote end of a four-wire serial link. It runs only on the clock the host sends and on an active-low frame line. While the frame line is low, the block is held cleared. Each rise of the frame line opens a transfer of 48 bit slots that moves data both ways at once. In each slot the host samples the outgoing bit on the falling clock edge and the block captures the incoming bit on that same edge. The block then moves its output on to the next slot at the following rising edge. Both directions send the highest-numbered slot first.

The inbound stream carries a command made of a direction flag, a 13-bit register address and 32 bits of write data. The two top slots are reserved. The outbound stream carries a status word made of a 10-bit board identifier, six lock flags and 32 bits of read data. The status word is captured once, when the frame opens. After the last slot has arrived, local register logic sees a one-period command-valid strobe while the decoded fields sit on the command outputs.

Top module: `serial_link_slave`

## Requirements
- R1: While `frame_n` is low, `cmd_valid` and `sdo` are 0, and both slot counters and the receive shift state are cleared asynchronously, including the case where the frame drops while `cmd_valid` is high.
- R2: Once `frame_n` rises, `sdo` shows status slot 47 before any clock edge occurs.
- R3: Each rising `sclk` edge that follows a captured falling edge moves `sdo` to the next lower slot. After slot 0 has gone out, `sdo` stays 0. The output slot never runs ahead of the slot count received.
- R4: Inbound bits are captured on falling edges, slot 47 first. Slot 0 sets `cmd_dir`, and slots 1 to 13 give `cmd_addr` bits 12 down to 0 (slot 1 is address bit 12).
- R5: Inbound slots 14 to 45 give `cmd_wdata` bits 31 down to 0 (slot 14 is bit 31, slot 45 is bit 0).
- R6: Inbound slots 46 and 47 have no effect on any command output.
- R7: Outbound slot n for n from 0 to 9 is `board_id[n]`. Slot 10+k is `lock_flags[k]`. Slot 16+m is `rd_data[m]`.
- R8: The status inputs are sampled on the rise of `frame_n`. Changing them later in the frame does not alter the bits sent.
- R9: `cmd_valid` goes high on the 48th falling edge of a frame and stays high until the next falling edge. A frame that closes before 48 falling edges raises no strobe.
- R10: Falling edges beyond the 48th in a frame are ignored: they give no second strobe, do not change the command outputs and leave `sdo` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| frame_n | input | 1 | Active-low frame line; low clears, rise opens a transfer |
| sdi | input | 1 | Serial command bits from the host |
| sdo | output | 1 | Serial status bits to the host |
| board_id | input | 10 | Board identifier sent in the status word |
| lock_flags | input | 6 | Lock indications sent in the status word |
| rd_data | input | 32 | Read data sent in the status word |
| cmd_valid | output | 1 | One-period strobe after a complete frame |
| cmd_dir | output | 1 | Direction flag of the received command |
| cmd_addr | output | 13 | Received register address |
| cmd_wdata | output | 32 | Received write data |

## Verification
The bench uses the default widths: a 10-bit identifier, 6 lock flags, a 13-bit address and 32-bit data. With these widths the frame is 48 slots, so two reserved inbound slots exist, and the vector table can set them to 1 or to 0 over otherwise identical commands. These widths also place the address and data fields at bit-reversed slot positions, so a swapped or shifted slot mapping shows up in the decoded values. The directed cases cover a frame cut short, a frame that drops while the strobe is high, clock edges past the 48th slot, and status inputs changed in mid-frame.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    // Default field widths of the link frame
    localparam int unsigned LNK_ID_W   = 10;
    localparam int unsigned LNK_LOCK_W = 6;
    localparam int unsigned LNK_ADDR_W = 13;
    localparam int unsigned LNK_DATA_W = 32;

    // Width of a counter that must hold the values 0..n
    function automatic int unsigned lnk_cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lnk_rx_deser.sv
module lnk_rx_deser #(
    parameter int unsigned SLOTS = 48,
    localparam int unsigned CNT_W = lnk_pkg::lnk_cnt_width(SLOTS)
) (
    input  logic             sclk,
    input  logic             frame_n,
    input  logic             sdi,
    output logic [SLOTS-1:0] rx_bits,
    output logic [CNT_W-1:0] rx_cnt,
    output logic             rx_done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SLOTS-1:0] bits;
        logic             done;
    } rx_state_t;

    rx_state_t rx_d, rx_q;

    // Next state: shift one slot per falling edge until the frame is full
    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        if (rx_q.cnt < CNT_W'(SLOTS)) begin
            rx_d.bits = {rx_q.bits[SLOTS-2:0], sdi};
            rx_d.cnt  = rx_q.cnt + 1'b1;
            rx_d.done = (rx_q.cnt == CNT_W'(SLOTS - 1));
        end
    end

    // Capture on falling clock edges, cleared while the frame line is low
    always_ff @(negedge sclk or negedge frame_n) begin
        if (!frame_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_bits = rx_q.bits;
    assign rx_cnt  = rx_q.cnt;
    assign rx_done = rx_q.done;

endmodule

// File: rtl/lnk_tx_ser.sv
module lnk_tx_ser #(
    parameter int unsigned SLOTS = 48,
    localparam int unsigned CNT_W = lnk_pkg::lnk_cnt_width(SLOTS)
) (
    input  logic             sclk,
    input  logic             frame_n,
    input  logic [SLOTS-1:0] status,
    input  logic [CNT_W-1:0] rx_cnt,
    output logic             sdo,
    output logic [CNT_W-1:0] tx_ptr
);

    logic [SLOTS-1:0] snap_d, snap_q;
    logic [CNT_W-1:0] ptr_d, ptr_q;
    logic [CNT_W-1:0] slot_idx;

    // Status word frozen on the opening edge of the frame
    always_comb begin
        snap_d = status;
    end

    always_ff @(posedge frame_n) begin
        snap_q <= snap_d;
    end

    // The output slot follows the count of captured bits, updated on rising
    // edges; a rising edge before the first capture leaves it at slot 0.
    always_comb begin
        ptr_d = rx_cnt;
    end

    always_ff @(posedge sclk or negedge frame_n) begin
        if (!frame_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_comb begin
        slot_idx = CNT_W'(SLOTS - 1) - ptr_q;
        if (!frame_n || (ptr_q >= CNT_W'(SLOTS))) begin
            sdo = 1'b0;
        end else begin
            sdo = snap_q[slot_idx];
        end
    end

    assign tx_ptr = ptr_q;

endmodule

// File: rtl/lnk_cmd_decode.sv
module lnk_cmd_decode #(
    parameter int unsigned SLOTS  = 48,
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned USED  = 1 + ADDR_W + DATA_W,
    localparam int unsigned RSVD  = SLOTS - USED
) (
    input  logic [SLOTS-1:0]  bits,
    output logic              dir,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    // Slot 0 holds the direction flag
    assign dir = bits[0];

    // Address: slot 1 is the top address bit, slot ADDR_W the bottom one
    for (genvar j = 0; j < ADDR_W; j++) begin : g_addr
        assign addr[j] = bits[ADDR_W - j];
    end

    // Write data follows the address, top data bit first
    for (genvar j = 0; j < DATA_W; j++) begin : g_wdata
        assign wdata[j] = bits[ADDR_W + DATA_W - j];
    end

    // Reserved top slots are dropped
    if (RSVD > 0) begin : g_rsvd
        logic unused_rsvd;
        assign unused_rsvd = ^bits[SLOTS-1:USED];
    end

endmodule

// File: rtl/serial_link_slave.sv
module serial_link_slave #(
    parameter int unsigned ID_W   = lnk_pkg::LNK_ID_W,
    parameter int unsigned LOCK_W = lnk_pkg::LNK_LOCK_W,
    parameter int unsigned ADDR_W = lnk_pkg::LNK_ADDR_W,
    parameter int unsigned DATA_W = lnk_pkg::LNK_DATA_W,
    localparam int unsigned FRAME_SLOTS = ID_W + LOCK_W + DATA_W,
    localparam int unsigned CNT_W = lnk_pkg::lnk_cnt_width(FRAME_SLOTS)
) (
    input  logic              sclk,
    input  logic              frame_n,
    input  logic              sdi,
    output logic              sdo,
    input  logic [ID_W-1:0]   board_id,
    input  logic [LOCK_W-1:0] lock_flags,
    input  logic [DATA_W-1:0] rd_data,
    output logic              cmd_valid,
    output logic              cmd_dir,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata
);

    logic [FRAME_SLOTS-1:0] rx_bits;
    logic [FRAME_SLOTS-1:0] status_word;
    logic [CNT_W-1:0]       rx_cnt;
    logic [CNT_W-1:0]       tx_ptr;
    logic                   rx_done;

    // Status word: slot index equals bit index
    assign status_word = {rd_data, lock_flags, board_id};

    lnk_rx_deser #(.SLOTS(FRAME_SLOTS)) i_rx (
        .sclk    (sclk),
        .frame_n (frame_n),
        .sdi     (sdi),
        .rx_bits (rx_bits),
        .rx_cnt  (rx_cnt),
        .rx_done (rx_done)
    );

    lnk_tx_ser #(.SLOTS(FRAME_SLOTS)) i_tx (
        .sclk    (sclk),
        .frame_n (frame_n),
        .status  (status_word),
        .rx_cnt  (rx_cnt),
        .sdo     (sdo),
        .tx_ptr  (tx_ptr)
    );

    lnk_cmd_decode #(
        .SLOTS  (FRAME_SLOTS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_dec (
        .bits  (rx_bits),
        .dir   (cmd_dir),
        .addr  (cmd_addr),
        .wdata (cmd_wdata)
    );

    assign cmd_valid = rx_done;

endmodule

// File: rtl/lnk_slave_checker.sv
module lnk_slave_checker #(
    parameter int unsigned SLOTS = 48,
    localparam int unsigned CNT_W = lnk_pkg::lnk_cnt_width(SLOTS)
) (
    input logic             sclk,
    input logic             frame_n,
    input logic             cmd_valid,
    input logic             sdo,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] tx_ptr
);

    // R9: the strobe lasts exactly one falling-edge period
    assert_valid_single_R9: assert property (
        @(negedge sclk) disable iff (!frame_n)
        cmd_valid |=> !cmd_valid
    ) else $error("strobe held past one period");

    // R9: the strobe only appears with a full frame captured
    assert_valid_full_frame_R9: assert property (
        @(negedge sclk) disable iff (!frame_n)
        cmd_valid |-> (rx_cnt == CNT_W'(SLOTS))
    ) else $error("strobe without full frame");

    // R10: the slot count never passes the frame length
    assert_rx_cnt_bound_R10: assert property (
        @(negedge sclk) disable iff (!frame_n)
        rx_cnt <= CNT_W'(SLOTS)
    ) else $error("slot count overrun");

    // R3: the output slot never runs ahead of the received count
    assert_tx_not_ahead_R3: assert property (
        @(posedge sclk) disable iff (!frame_n)
        tx_ptr <= rx_cnt
    ) else $error("output slot ahead of input");

    // R1: quiet outputs while the frame line is low
    always @(posedge sclk) begin
        if (frame_n === 1'b0) begin
            assert_idle_quiet_R1: assert (cmd_valid == 1'b0 && sdo == 1'b0)
                else $error("outputs active with frame low");
        end
    end

endmodule

bind serial_link_slave lnk_slave_checker #(.SLOTS(FRAME_SLOTS)) i_chk (
    .sclk      (sclk),
    .frame_n   (frame_n),
    .cmd_valid (cmd_valid),
    .sdo       (sdo),
    .rx_cnt    (rx_cnt),
    .tx_ptr    (tx_ptr)
);

// File: tb/test_serial_link_slave.sv
module test_serial_link_slave;

    localparam time CLK_PERIOD = 20ns;
    localparam int  NSLOT = 48;

    typedef struct packed {
        logic [47:0] cmd;
        logic [9:0]  id;
        logic [5:0]  lk;
        logic [31:0] rd;
    } vec_t;

    // Command bit index = slot number
    localparam vec_t VECS [4] = '{
        '{cmd: 48'h0000_0000_0001, id: 10'h2A5, lk: 6'h15, rd: 32'hDEAD_BEEF},
        '{cmd: 48'hC000_1234_5678, id: 10'h0F0, lk: 6'h3C, rd: 32'h0123_4567},
        '{cmd: 48'h0000_1234_5678, id: 10'h30F, lk: 6'h01, rd: 32'h8000_0001},
        '{cmd: 48'h3FFF_FFFF_FFFE, id: 10'h3FF, lk: 6'h3F, rd: 32'hFFFF_FFFF}
    };

    logic        sclk = 1'b0;
    logic        frame_n = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [9:0]  board_id = '0;
    logic [5:0]  lock_flags = '0;
    logic [31:0] rd_data = '0;
    logic        cmd_valid;
    logic        cmd_dir;
    logic [12:0] cmd_addr;
    logic [31:0] cmd_wdata;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) sclk = ~sclk;

    serial_link_slave i_serial_link_slave (
        .sclk       (sclk),
        .frame_n    (frame_n),
        .sdi        (sdi),
        .sdo        (sdo),
        .board_id   (board_id),
        .lock_flags (lock_flags),
        .rd_data    (rd_data),
        .cmd_valid  (cmd_valid),
        .cmd_dir    (cmd_dir),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_addr(input logic [47:0] c);
        logic [12:0] a;
        for (int j = 0; j < 13; j++) a[j] = c[13 - j];
        return a;
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [47:0] c);
        logic [31:0] w;
        for (int j = 0; j < 32; j++) w[j] = c[45 - j];
        return w;
    endfunction

    // One frame of n_slots slots. perturb: change status mid-frame.
    // extra: give two falling edges past the frame before closing it.
    task automatic run_frame(input vec_t v, input int n_slots,
                             input bit perturb, input bit extra);
        logic [47:0] exp_st;
        logic [47:0] seen;
        bit          early_valid;
        board_id   = v.id;
        lock_flags = v.lk;
        rd_data    = v.rd;
        exp_st     = {v.rd, v.lk, v.id};
        seen       = '0;
        early_valid = 1'b0;
        @(posedge sclk); #2;
        frame_n = 1'b1;
        for (int k = 0; k < n_slots; k++) begin
            sdi = v.cmd[NSLOT - 1 - k];
            #3;
            seen[NSLOT - 1 - k] = sdo;
            if (k == 0) check(sdo == exp_st[47], "R2", "first slot before any edge", 64'(sdo), 64'(exp_st[47]));
            if (perturb && k == 5) begin
                board_id = ~v.id; lock_flags = ~v.lk; rd_data = ~v.rd;
            end
            @(negedge sclk); #1;
            if (k < NSLOT - 1 && cmd_valid) early_valid = 1'b1;
            @(posedge sclk); #2;
        end
        check(!early_valid, "R9", "no strobe before the 48th edge", 64'(early_valid), 64'd0);
        if (n_slots == NSLOT) begin
            if (perturb)
                check(seen == exp_st, "R8", "status frozen at frame start", 64'(seen), 64'(exp_st));
            else
                check(seen == exp_st, "R7", "status slot layout", 64'(seen), 64'(exp_st));
            check(cmd_valid == 1'b1, "R9", "strobe after full frame", 64'(cmd_valid), 64'd1);
            check(cmd_dir == v.cmd[0], "R4", "direction flag", 64'(cmd_dir), 64'(v.cmd[0]));
            check(cmd_addr == exp_addr(v.cmd), "R4", "address", 64'(cmd_addr), 64'(exp_addr(v.cmd)));
            check(cmd_wdata == exp_wdata(v.cmd), "R5", "write data", 64'(cmd_wdata), 64'(exp_wdata(v.cmd)));
            check(sdo == 1'b0, "R3", "sdo low after last slot", 64'(sdo), 64'd0);
            if (extra) begin
                sdi = 1'b1;
                @(negedge sclk); #1;
                check(cmd_valid == 1'b0, "R9", "strobe drops at next edge", 64'(cmd_valid), 64'd0);
                @(negedge sclk); #1;
                check(cmd_valid == 1'b0, "R10", "no second strobe", 64'(cmd_valid), 64'd0);
                check(cmd_wdata == exp_wdata(v.cmd), "R10", "fields unchanged past frame",
                      64'(cmd_wdata), 64'(exp_wdata(v.cmd)));
                @(posedge sclk); #2;
                check(sdo == 1'b0, "R10", "sdo stays low past frame", 64'(sdo), 64'd0);
            end
        end else begin
            check(seen[47 -: 8] == exp_st[47 -: 8], "R3", "partial frame order",
                  64'(seen[47 -: 8]), 64'(exp_st[47 -: 8]));
        end
        frame_n = 1'b0;
        sdi     = 1'b0;
        #1;
        check(cmd_valid == 1'b0 && sdo == 1'b0, "R1", "outputs cleared on frame low",
              64'({cmd_valid, sdo}), 64'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stimulus
        #(CLK_PERIOD * 3 + 3ns);
        check(cmd_valid == 1'b0, "R1", "reset strobe", 64'(cmd_valid), 64'd0);
        check(sdo == 1'b0, "R1", "reset sdo", 64'(sdo), 64'd0);

        // Table of vectors, each a full frame
        foreach (VECS[i]) run_frame(VECS[i], NSLOT, 1'b0, 1'b1);

        // R6: reserved slots set vs clear give identical fields
        run_frame(VECS[1], NSLOT, 1'b0, 1'b0);

        // R9: frame closed early, then a normal frame still works
        run_frame(VECS[3], 20, 1'b0, 1'b0);
        run_frame(VECS[0], NSLOT, 1'b0, 1'b1);

        // R8: status changed mid-frame
        run_frame(VECS[2], NSLOT, 1'b1, 1'b0);

        #(CLK_PERIOD * 2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule